// File: doc/BRIEF.md
# Posted Memory Write Buffer

This block holds memory writes travelling in one direction across a bridge. Writes are taken on the write side, one dword per beat, and sent on the drain side. Each beat carries an address, data, byte enables and a burst-end mark. The initiator does not wait for the far side to complete the write. Draining starts as soon as one entry is stored. A burst on the drain side closes when the initiator ended it, or at the last dword of a 4 KB address page. The next entry then opens a new burst with a fresh address.

The buffer also keeps I/O transactions in order with posted writes. When an I/O transaction is queued, it is given its grant only after every write accepted before it has drained. Writes accepted from that moment on are held back until the I/O is reported done. A soft flush input empties the buffer at once.

Top module: `pwb_buffer`

## Requirements
- R1: After reset the buffer is empty: `rd_valid` and `io_grant` are 0, and `wr_ready` is 1 for a postable command.
- R2: Only command codes 4'b0111 (memory write) and 4'b1111 (memory write and invalidate) are posted. For any other code on `wr_cmd`, `wr_ready` is 0 and nothing is stored.
- R3: The buffer holds DEPTH (32) dwords. When all 32 are held, `wr_ready` is 0 and the write side stalls. No beat is lost or overwritten.
- R4: A beat accepted (with `wr_valid` and `wr_ready` both high) at one clock edge can be presented on the drain side from the next cycle. Entries leave in order of acceptance with their address, data and byte enables intact. An entry is removed on an edge where `rd_valid` and `rd_ready` are both high.
- R5: A beat whose byte address has bits [11:2] all ones is the last dword of a 4 KB page. In the cycle it is accepted, `wr_disconnect` is 1, and the entry drains with `rd_last` = 1.
- R6: A beat accepted with `wr_last` = 1 drains with `rd_last` = 1. The entry that follows any `rd_last` entry drains with `rd_first` = 1. So does the first entry after reset or flush.
- R7: A pulse on `io_req` while no I/O is pending sets a barrier. `io_grant` becomes 1 once every entry accepted before that edge has drained. Entries accepted at that edge or later are not presented on the drain side while the barrier stands.
- R8: A pulse on `io_done` removes the barrier and drops `io_grant` on the next cycle. The held-back entries then drain.
- R9: A pulse on `flush` empties the buffer and removes any barrier. In the next cycle `rd_valid` and `io_grant` are 0, and the buffer behaves as just reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Soft reset: empty the buffer and drop the barrier |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Beat can be taken (postable command and space left) |
| wr_cmd | input | 4 | Bus command of the beat |
| wr_addr | input | 32 | Byte address of the beat |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables |
| wr_last | input | 1 | Initiator ends its burst with this beat |
| wr_disconnect | output | 1 | Accepted beat is at a page end; burst is cut |
| rd_valid | output | 1 | Head entry offered on the drain side |
| rd_ready | input | 1 | Far side takes the head entry |
| rd_addr | output | 32 | Address of head entry |
| rd_data | output | 32 | Data of head entry |
| rd_be | output | 4 | Byte enables of head entry |
| rd_first | output | 1 | Head entry opens a burst |
| rd_last | output | 1 | Head entry closes a burst |
| io_req | input | 1 | I/O transaction queued behind current writes |
| io_done | input | 1 | Queued I/O transaction has completed |
| io_grant | output | 1 | All writes ahead of the I/O have drained |

## Verification
Some rules are checked by assertions on every cycle. The occupancy never goes above DEPTH or below zero. No entry leaves while the I/O grant is high. A page-end address on the drain side always carries the burst-end mark. The cycle after a flush shows an empty drain side. Other rules can only be shown by the bench's scenarios, which compare against a reference model every cycle. These are the exact data order, the first and last marks over a page crossing, and the stall at the 32nd entry. They also include the rejection of non-posted commands and the split of writes into those ahead of and behind an I/O barrier.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int BEW = DW / 8;

  localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
  localparam logic [3:0] CMD_MEM_WRI = 4'b1111;

  typedef struct packed {
    logic [AW-1:0]  addr;
    logic [DW-1:0]  data;
    logic [BEW-1:0] be;
    logic           first;
    logic           last;
  } pwb_entry_t;
endpackage

// File: rtl/pwb_store.sv
module pwb_store
  import pwb_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       push,
  input  pwb_entry_t push_entry,
  input  logic       pop,
  output pwb_entry_t head,
  output logic [CW-1:0] count,
  output logic       full
);
  pwb_entry_t mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) wptr_d = wptr_q + 1'b1;
      if (pop)  rptr_d = rptr_q + 1'b1;
      cnt_d = cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wptr_q] <= push_entry;
  end

  assign head  = mem[rptr_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CW'(DEPTH)));
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
endmodule

// File: rtl/pwb_order.sv
module pwb_order #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          io_req,
  input  logic          io_done,
  input  logic          pop,
  input  logic [CW-1:0] occupancy,
  output logic          drain_ok,
  output logic          io_grant
);
  logic          armed_q, armed_d;
  logic [CW-1:0] ahead_q, ahead_d;

  always_comb begin
    armed_d = armed_q;
    ahead_d = ahead_q;
    if (flush) begin
      armed_d = 1'b0;
      ahead_d = '0;
    end else if (!armed_q) begin
      if (io_req) begin
        armed_d = 1'b1;
        ahead_d = occupancy - CW'(pop);
      end
    end else if (io_done) begin
      armed_d = 1'b0;
      ahead_d = '0;
    end else if (pop) begin
      ahead_d = ahead_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      ahead_q <= '0;
    end else begin
      armed_q <= armed_d;
      ahead_q <= ahead_d;
    end
  end

  assign io_grant = armed_q && (ahead_q == '0);
  assign drain_ok = !io_grant;

  a_r7_grant_blocks_drain: assert property (@(posedge clk) disable iff (!rst_n)
    io_grant |-> !pop);
  a_r7_ahead_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (ahead_q <= occupancy));
endmodule

// File: rtl/pwb_buffer.sv
module pwb_buffer
  import pwb_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int PAGE_BITS = 12,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [3:0]     wr_cmd,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [BEW-1:0] wr_be,
  input  logic           wr_last,
  output logic           wr_disconnect,
  output logic           rd_valid,
  input  logic           rd_ready,
  output logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic [BEW-1:0] rd_be,
  output logic           rd_first,
  output logic           rd_last,
  input  logic           io_req,
  input  logic           io_done,
  output logic           io_grant
);
  logic          rst_s1_q, rst_sync_n;
  logic          push, pop, full, drain_ok, page_end, cmd_ok;
  logic          open_q, open_d;
  logic [CW-1:0] count;
  pwb_entry_t    in_e, head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  assign cmd_ok   = (wr_cmd == CMD_MEM_WR) || (wr_cmd == CMD_MEM_WRI);
  assign page_end = &wr_addr[PAGE_BITS-1:2];
  assign wr_ready = cmd_ok && !full;
  assign push     = wr_valid && wr_ready;
  assign wr_disconnect = push && page_end;

  always_comb begin
    in_e.addr  = wr_addr;
    in_e.data  = wr_data;
    in_e.be    = wr_be;
    in_e.first = open_q;
    in_e.last  = wr_last || page_end;
  end

  always_comb begin
    open_d = open_q;
    if (flush)     open_d = 1'b1;
    else if (push) open_d = in_e.last;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) open_q <= 1'b1;
    else             open_q <= open_d;
  end

  pwb_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .flush(flush),
    .push(push), .push_entry(in_e), .pop(pop),
    .head(head), .count(count), .full(full)
  );

  pwb_order #(.DEPTH(DEPTH)) u_order (
    .clk(clk), .rst_n(rst_sync_n), .flush(flush),
    .io_req(io_req), .io_done(io_done), .pop(pop),
    .occupancy(count), .drain_ok(drain_ok), .io_grant(io_grant)
  );

  assign rd_valid = (count != '0) && drain_ok;
  assign pop      = rd_valid && rd_ready && !flush;
  assign rd_addr  = head.addr;
  assign rd_data  = head.data;
  assign rd_be    = head.be;
  assign rd_first = head.first;
  assign rd_last  = head.last;

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush |=> (!rd_valid && !io_grant));
  a_r5_page_end_closes: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_valid && (&rd_addr[PAGE_BITS-1:2])) |-> rd_last);
  a_r8_done_drops_grant: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_grant && io_done && !flush) |=> !io_grant);
endmodule

// File: tb/pwb_buffer_test.sv
module pwb_buffer_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic        first;
    logic        last;
  } ent_t;

  logic clk = 1'b0;
  logic rst_n, flush, wr_valid, wr_last, rd_ready, io_req, io_done;
  logic [3:0]  wr_cmd, wr_be;
  logic [31:0] wr_addr, wr_data;
  logic wr_ready, wr_disconnect, rd_valid, rd_first, rd_last, io_grant;
  logic [31:0] rd_addr, rd_data;
  logic [3:0]  rd_be;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  ent_t q[$];
  bit   m_open = 1'b1;
  bit   m_armed = 1'b0;
  int   m_ahead = 0;

  pwb_buffer uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_cmd(wr_cmd),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be), .wr_last(wr_last),
    .wr_disconnect(wr_disconnect),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_be(rd_be), .rd_first(rd_first), .rd_last(rd_last),
    .io_req(io_req), .io_done(io_done), .io_grant(io_grant)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected <= 5000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one clock: compare outputs against the model, then advance the model
  task automatic cyc();
    bit e_ok, e_rdy, e_grant, e_rv, e_page, push, pop;
    #1;
    e_ok    = (wr_cmd == 4'b0111) || (wr_cmd == 4'b1111);
    e_rdy   = e_ok && (q.size() < 32);
    e_grant = m_armed && (m_ahead == 0);
    e_rv    = (q.size() > 0) && !e_grant;
    e_page  = (wr_addr[11:2] == 10'h3FF);
    chk(e_ok ? "R3" : "R2", "wr_ready", 32'(wr_ready), 32'(e_rdy));
    chk("R7", "io_grant", 32'(io_grant), 32'(e_grant));
    chk("R4", "rd_valid", 32'(rd_valid), 32'(e_rv));
    chk("R5", "wr_disconnect", 32'(wr_disconnect), 32'(wr_valid && e_rdy && e_page));
    if (e_rv) begin
      chk("R4", "rd_addr", rd_addr, q[0].addr);
      chk("R4", "rd_data", rd_data, q[0].data);
      chk("R4", "rd_be", 32'(rd_be), 32'(q[0].be));
      chk("R6", "rd_first", 32'(rd_first), 32'(q[0].first));
      chk("R6", "rd_last", 32'(rd_last), 32'(q[0].last));
    end
    push = wr_valid && e_rdy;
    pop  = e_rv && rd_ready;
    @(posedge clk);
    if (flush) begin
      q.delete();
      m_open = 1'b1;
      m_armed = 1'b0;
      m_ahead = 0;
    end else begin
      if (!m_armed) begin
        if (io_req) begin
          m_armed = 1'b1;
          m_ahead = q.size() - int'(pop);
        end
      end else if (io_done) begin
        m_armed = 1'b0;
        m_ahead = 0;
      end else if (pop) begin
        m_ahead--;
      end
      if (pop) void'(q.pop_front());
      if (push) begin
        ent_t e;
        e.addr = wr_addr; e.data = wr_data; e.be = wr_be;
        e.first = m_open; e.last = wr_last || e_page;
        m_open = e.last;
        q.push_back(e);
      end
    end
    @(negedge clk);
  endtask

  task automatic idle_in();
    flush = 0; wr_valid = 0; wr_last = 0; io_req = 0; io_done = 0;
    wr_cmd = 4'b0111; wr_addr = '0; wr_data = '0; wr_be = 4'hF;
  endtask

  task automatic beat(logic [31:0] a, logic [31:0] d, logic [3:0] be, logic last);
    wr_valid = 1; wr_addr = a; wr_data = d; wr_be = be; wr_last = last;
  endtask

  initial begin
    rst_n = 0; rd_ready = 0;
    idle_in();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: empty after reset
    chk("R1", "rd_valid after reset", 32'(rd_valid), 32'h0);
    chk("R1", "io_grant after reset", 32'(io_grant), 32'h0);
    chk("R1", "wr_ready after reset", 32'(wr_ready), 32'h1);

    // R4 R6: short burst with simultaneous drain, memory write and invalidate
    rd_ready = 1;
    for (int i = 0; i < 4; i++) begin
      wr_cmd = (i[0]) ? 4'b1111 : 4'b0111;
      beat(32'h0000_1000 + 32'(i*4), 32'hA000_0000 + 32'(i), 4'(i+1), i == 3);
      cyc();
    end
    idle_in();
    repeat (3) cyc();

    // R2: non-postable commands refused
    wr_cmd = 4'b0110; beat(32'h0000_2000, 32'h1111_1111, 4'hF, 1); cyc();
    wr_cmd = 4'b0011; cyc();
    idle_in(); cyc();
    chk("R2", "nothing stored from read/io command", 32'(rd_valid), 32'h0);

    // R3: fill to 32 with the drain stalled, then drain all
    rd_ready = 0;
    for (int i = 0; i < 36; i++) begin
      beat(32'h0001_0000 + 32'(i*4), 32'hB000_0000 + 32'(i), 4'hF, 1'b0);
      cyc();
    end
    idle_in();
    chk("R3", "wr_ready low when 32 held", 32'(wr_ready), 32'h0);
    rd_ready = 1;
    repeat (34) cyc();

    // R5 R6: burst crossing a 4 KB page end
    for (int i = 0; i < 4; i++) begin
      beat(32'h0000_2FF8 + 32'(i*4), 32'hC000_0000 + 32'(i), 4'hC, i == 3);
      cyc();
    end
    idle_in();
    repeat (5) cyc();

    // R7 R8: barrier with three writes ahead and three behind
    rd_ready = 0;
    for (int i = 0; i < 3; i++) begin
      beat(32'h0000_4000 + 32'(i*4), 32'hD000_0000 + 32'(i), 4'hF, i == 2);
      cyc();
    end
    io_req = 1;
    beat(32'h0000_5000, 32'hE000_0000, 4'h3, 0); cyc();
    io_req = 0;
    beat(32'h0000_5004, 32'hE000_0001, 4'h3, 0); cyc();
    beat(32'h0000_5008, 32'hE000_0002, 4'h3, 1); cyc();
    idle_in();
    rd_ready = 1;
    repeat (6) cyc();
    chk("R7", "grant once earlier writes drained", 32'(io_grant), 32'h1);
    chk("R7", "later writes held behind barrier", 32'(rd_valid), 32'h0);
    io_done = 1; cyc();
    io_done = 0;
    chk("R8", "grant dropped after io_done", 32'(io_grant), 32'h0);
    repeat (5) cyc();

    // R7: barrier on an empty buffer grants at once
    io_req = 1; cyc(); io_req = 0;
    chk("R7", "grant with nothing ahead", 32'(io_grant), 32'h1);
    io_done = 1; cyc(); io_done = 0; cyc();

    // R9: flush with entries and a standing barrier
    rd_ready = 0;
    for (int i = 0; i < 5; i++) begin
      beat(32'h0000_6000 + 32'(i*4), 32'hF000_0000 + 32'(i), 4'hF, 0);
      cyc();
    end
    idle_in();
    io_req = 1; cyc(); io_req = 0;
    flush = 1; cyc(); flush = 0;
    chk("R9", "rd_valid after flush", 32'(rd_valid), 32'h0);
    chk("R9", "io_grant after flush", 32'(io_grant), 32'h0);
    rd_ready = 1;
    beat(32'h0000_7000, 32'h1234_5678, 4'h5, 1); cyc();
    idle_in();
    repeat (3) cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule